// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Latch

This block holds one mutual-exclusion token that two agents, a left port and a right port, share. Each port has a chip select, a write strobe, a one-bit write value and a one-bit status output. A write of 0 asks for the token and a write of 1 gives it back. The status output of a port is 0 while that port owns the token and 1 at all other times. Software on either side takes the token by writing 0 and then reading its own status.

Unlike a plain test-and-set flag, the latch remembers a request that lost. If a port asks while the other side owns the token, the request is stored as pending. When the owner writes 1, the token moves straight to the waiting port on the same clock edge, and that port does not have to write again. A port that no longer wants the token writes 1 to withdraw its pending request. If both ports ask in the same cycle while the token is free, the left port gets it and the right port's request is stored as pending.

The status outputs come straight from registered state. Every write is taken on a rising clock edge, and its effect shows on the outputs right after that edge.

Top module: `sem_latch2`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it, the token is free, no request is pending, and both status outputs are 1.
- R2: A write (chip select 1, write strobe 1) of 0 from one port while the token is free gives that port the token. After that edge its status is 0 and the other port's status is 1. Both status outputs are never 0 at the same time.
- R3: A write of 0 from one port while the other port owns the token leaves both status outputs unchanged at the next edge.
- R4: A 0 write from a port while the other port owns the token is stored as pending. A later write of 1 from the owner hands the token to that port at the same edge: its status becomes 0 and the owner's status becomes 1.
- R5: A write of 1 from the owner with no pending request from the other port frees the token, so both status outputs read 1 after that edge.
- R6: A write of 1 from a port that does not own the token cancels that port's pending request. A later release by the owner then frees the token and does not hand it over.
- R7: When both ports write 0 in the same cycle while the token is free, the left port gets the token (left status 0, right status 1) and the right port's request becomes pending.
- R8: A cycle in which neither port has both chip select and write strobe at 1 changes neither status output nor any pending request.
- R9: A write of 0 from the port that already owns the token changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| l_cs | input | 1 | Left port chip select |
| l_we | input | 1 | Left port write strobe |
| l_din | input | 1 | Left port write value: 0 requests, 1 releases |
| l_dout | output | 1 | Left port status: 0 when left owns the token |
| r_cs | input | 1 | Right port chip select |
| r_we | input | 1 | Right port write strobe |
| r_din | input | 1 | Right port write value: 0 requests, 1 releases |
| r_dout | output | 1 | Right port status: 0 when right owns the token |

## Verification
Every write result is due one edge after the write: the new owner, the handover to a waiting port and the release to free all show on the status outputs right after the rising edge that takes the write. The bench drives inputs on the falling edge and samples 1 ns after the following rising edge, so exactly one register stage lies between stimulus and check. A pending request cannot be seen at the ports, so after each stimulus a second cycle makes the owner release, and the status outputs then show whether a request was stored or cancelled.

// File: rtl/sem_pkg.sv
package sem_pkg;

    // Who owns the token.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } own_e;

    // Action a port performs in one cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_TAKE = 2'd1,
        OP_GIVE = 2'd2
    } op_e;

    typedef struct packed {
        own_e owner;
        logic pend_l;
        logic pend_r;
    } sem_state_t;

    localparam sem_state_t SEM_RESET = '{owner: OWN_NONE, pend_l: 1'b0, pend_r: 1'b0};

    function automatic op_e decode_op(input logic cs, input logic we, input logic d);
        if (!(cs && we)) return OP_IDLE;
        return d ? OP_GIVE : OP_TAKE;
    endfunction

    // Status bit seen by a port: 0 while it owns the token.
    function automatic logic status_bit(input own_e owner, input own_e me);
        return (owner == me) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec
    import sem_pkg::*;
(
    input  logic cs,
    input  logic we,
    input  logic din,
    output op_e  op
);
    always_comb op = decode_op(cs, we, din);
endmodule

// File: rtl/sem_next.sv
module sem_next
    import sem_pkg::*;
(
    input  sem_state_t cur,
    input  op_e        l_op,
    input  op_e        r_op,
    output sem_state_t nxt
);
    logic want_l;
    logic want_r;

    // Pending intent after this cycle's writes, valid when the other side owns.
    always_comb begin
        want_l = (cur.pend_l || (l_op == OP_TAKE)) && (l_op != OP_GIVE);
        want_r = (cur.pend_r || (r_op == OP_TAKE)) && (r_op != OP_GIVE);
    end

    always_comb begin
        nxt = cur;
        unique case (cur.owner)
            OWN_NONE: begin
                nxt.pend_l = 1'b0;
                nxt.pend_r = 1'b0;
                if (l_op == OP_TAKE) begin
                    nxt.owner  = OWN_LEFT;
                    nxt.pend_r = (r_op == OP_TAKE);
                end else if (r_op == OP_TAKE) begin
                    nxt.owner = OWN_RIGHT;
                end
            end
            OWN_LEFT: begin
                nxt.pend_l = 1'b0;
                if (l_op == OP_GIVE) begin
                    nxt.owner  = want_r ? OWN_RIGHT : OWN_NONE;
                    nxt.pend_r = 1'b0;
                end else begin
                    nxt.pend_r = want_r;
                end
            end
            OWN_RIGHT: begin
                nxt.pend_r = 1'b0;
                if (r_op == OP_GIVE) begin
                    nxt.owner  = want_l ? OWN_LEFT : OWN_NONE;
                    nxt.pend_l = 1'b0;
                end else begin
                    nxt.pend_l = want_l;
                end
            end
            default: nxt = SEM_RESET;
        endcase
    end
endmodule

// File: rtl/sem_state_reg.sv
module sem_state_reg
    import sem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sem_state_t d,
    output sem_state_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= SEM_RESET;
        else     q <= d;
    end
endmodule

// File: rtl/sem_latch2.sv
module sem_latch2
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic l_cs,
    input  logic l_we,
    input  logic l_din,
    output logic l_dout,
    input  logic r_cs,
    input  logic r_we,
    input  logic r_din,
    output logic r_dout
);
    localparam int NPORT = 2;

    logic [NPORT-1:0] cs_v;
    logic [NPORT-1:0] we_v;
    logic [NPORT-1:0] din_v;
    op_e              op_v [NPORT];

    sem_state_t cur;
    sem_state_t nxt;

    assign cs_v  = {r_cs, l_cs};
    assign we_v  = {r_we, l_we};
    assign din_v = {r_din, l_din};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        sem_port_dec u_dec (
            .cs  (cs_v[p]),
            .we  (we_v[p]),
            .din (din_v[p]),
            .op  (op_v[p])
        );
    end

    sem_next u_next (
        .cur  (cur),
        .l_op (op_v[0]),
        .r_op (op_v[1]),
        .nxt  (nxt)
    );

    sem_state_reg u_state (
        .clk (clk),
        .rst (rst),
        .d   (nxt),
        .q   (cur)
    );

    assign l_dout = status_bit(cur.owner, OWN_LEFT);
    assign r_dout = status_bit(cur.owner, OWN_RIGHT);
endmodule

// File: rtl/sem_latch2_chk.sv
module sem_latch2_chk (
    input logic clk,
    input logic rst,
    input logic l_cs,
    input logic l_we,
    input logic l_din,
    input logic l_dout,
    input logic r_cs,
    input logic r_we,
    input logic r_din,
    input logic r_dout,
    input logic pend_l,
    input logic pend_r
);
    logic l_take, l_give, r_take, r_give;
    assign l_take = l_cs && l_we && !l_din;
    assign l_give = l_cs && l_we &&  l_din;
    assign r_take = r_cs && r_we && !r_din;
    assign r_give = r_cs && r_we &&  r_din;

    assert_after_reset_R1: assert property (@(posedge clk)
        rst |=> (l_dout && r_dout));

    assert_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        (l_dout || r_dout));

    assert_take_free_R2: assert property (@(posedge clk) disable iff (rst)
        (l_dout && r_dout && l_take) |=> (!l_dout && r_dout));

    assert_blocked_R3: assert property (@(posedge clk) disable iff (rst)
        (!r_dout && l_take && !r_give) |=> ($stable(l_dout) && $stable(r_dout)));

    assert_handover_R4: assert property (@(posedge clk) disable iff (rst)
        (!l_dout && pend_r && l_give && !r_give) |=> (!r_dout && l_dout));

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (!l_dout && !pend_r && l_give && !r_take) |=> (l_dout && r_dout));

    assert_tie_R7: assert property (@(posedge clk) disable iff (rst)
        (l_dout && r_dout && l_take && r_take) |=> (!l_dout && r_dout && pend_r));

    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!(l_cs && l_we) && !(r_cs && r_we)) |=>
            ($stable(l_dout) && $stable(r_dout) && $stable(pend_l) && $stable(pend_r)));
endmodule

bind sem_latch2 sem_latch2_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .l_cs   (l_cs),
    .l_we   (l_we),
    .l_din  (l_din),
    .l_dout (l_dout),
    .r_cs   (r_cs),
    .r_we   (r_we),
    .r_din  (r_din),
    .r_dout (r_dout),
    .pend_l (cur.pend_l),
    .pend_r (cur.pend_r)
);

// File: tb/test_sem_latch2.sv
`timescale 1ns/1ps
module test_sem_latch2;
    localparam real HALF = 2.0;
    localparam int  MAX_CYC = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_cs = 0, l_we = 0, l_din = 1, r_cs = 0, r_we = 0, r_din = 1;
    logic l_dout, r_dout;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench model: 0 free, 1 left owns, 2 right owns.
    int m_own = 0;
    bit m_pl = 0, m_pr = 0;

    always #(HALF) clk = ~clk;

    sem_latch2 i_sem_latch2 (
        .clk(clk), .rst(rst),
        .l_cs(l_cs), .l_we(l_we), .l_din(l_din), .l_dout(l_dout),
        .r_cs(r_cs), .r_we(r_we), .r_din(r_din), .r_dout(r_dout)
    );

    task automatic check(input string req, input logic el, input logic er);
        n_chk++;
        if (l_dout !== el || r_dout !== er) begin
            n_bad++;
            $display("FAIL %s: l_dout=%b r_dout=%b expected %b %b", req, l_dout, r_dout, el, er);
        end
    endtask

    // Model update from the requirement text.
    task automatic model(input bit lt, input bit lg, input bit rt, input bit rg);
        bit wl, wr;
        wl = (m_pl || lt) && !lg;
        wr = (m_pr || rt) && !rg;
        case (m_own)
            0: begin
                m_pl = 0; m_pr = 0;
                if (lt) begin m_own = 1; m_pr = rt; end      // R7 tie
                else if (rt) m_own = 2;
            end
            1: begin
                m_pl = 0;
                if (lg) begin m_own = wr ? 2 : 0; m_pr = 0; end
                else m_pr = wr;
            end
            default: begin
                m_pr = 0;
                if (rg) begin m_own = wl ? 1 : 0; m_pl = 0; end
                else m_pl = wl;
            end
        endcase
    endtask

    function automatic string label(input bit lt, input bit lg, input bit rt, input bit rg);
        if (!(lt || lg || rt || rg)) return "R8";
        if (m_own == 0 && lt && rt) return "R7";
        if (m_own == 0) return (lt || rt) ? "R2" : "R6";
        if ((m_own == 1 && lg) || (m_own == 2 && rg)) begin
            if ((m_own == 1 && (m_pr || rt) && !rg) || (m_own == 2 && (m_pl || lt) && !lg))
                return "R4";
            return "R5";
        end
        if ((m_own == 1 && rt) || (m_own == 2 && lt)) return "R3";
        if ((m_own == 1 && rg) || (m_own == 2 && lg)) return "R6";
        return "R9";
    endfunction

    // One cycle: drive at negedge, sample 1 ns after the next posedge.
    task automatic step(input logic [2:0] lb, input logic [2:0] rb, input string req_in);
        bit lt, lg, rt, rg;
        string req;
        @(negedge clk);
        {l_cs, l_we, l_din} = lb;
        {r_cs, r_we, r_din} = rb;
        lt = lb[2] && lb[1] && !lb[0];
        lg = lb[2] && lb[1] &&  lb[0];
        rt = rb[2] && rb[1] && !rb[0];
        rg = rb[2] && rb[1] &&  rb[0];
        req = (req_in == "") ? label(lt, lg, rt, rg) : req_in;
        @(posedge clk);
        #1;
        model(lt, lg, rt, rg);
        check(req, !(m_own == 1), !(m_own == 2));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        {l_cs, l_we, l_din, r_cs, r_we, r_din} = 6'b001001;
        @(posedge clk); @(posedge clk);
        #1;
        m_own = 0; m_pl = 0; m_pr = 0;
        check("R1", 1'b1, 1'b1);
        @(negedge clk);
        rst = 0;
    endtask

    localparam logic [2:0] IDLE = 3'b000;
    localparam logic [2:0] TAKE = 3'b110;
    localparam logic [2:0] GIVE = 3'b111;

    initial begin
        // Directed checks.
        do_reset();
        step(IDLE, IDLE, "R1");
        step(3'b100, 3'b010, "R8");   // strobe or select alone
        step(TAKE, IDLE, "R2");
        step(TAKE, IDLE, "R9");
        step(IDLE, TAKE, "R3");
        step(GIVE, IDLE, "R4");
        step(IDLE, GIVE, "R5");
        step(TAKE, TAKE, "R7");
        step(IDLE, GIVE, "R6");
        step(GIVE, IDLE, "R6");

        // Sweep: 5 start states x 64 input combinations, then a probe release.
        for (int s = 0; s < 5; s++) begin
            for (int c = 0; c < 64; c++) begin
                do_reset();
                case (s)
                    1: step(TAKE, IDLE, "R2");
                    2: begin step(TAKE, IDLE, "R2"); step(IDLE, TAKE, "R3"); end
                    3: step(IDLE, TAKE, "R2");
                    4: begin step(IDLE, TAKE, "R2"); step(TAKE, IDLE, "R3"); end
                    default: ;
                endcase
                step(c[2:0], c[5:3], "");
                if (m_own == 1)      step(GIVE, IDLE, m_pr ? "R4" : "R6");
                else if (m_own == 2) step(IDLE, GIVE, m_pl ? "R4" : "R6");
                else                 step(IDLE, IDLE, "R8");
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule